// File: doc/BRIEF.md
# In-Order Retire Slot Tracker

This block follows instructions from the moment they are dispatched until they retire, strictly in program order. It is a circular queue with a fixed number of slots. A dispatched instruction states how many micro-ops it carries. That count is normalized: zero becomes one, and any value above the queue depth becomes the depth. The instruction then claims that many consecutive slots. The block returns a token, which is the index of the first slot claimed. The execution units later report completion by presenting that token on the completion port.

Each cycle the tracker looks at the oldest entry. If that entry has completed, it retires and gives all of its slots back. Further entries may follow it in the same cycle, up to a parameterized per-cycle limit, and a limit of zero removes the cap. Each retirement is reported on its own lane with the entry's token and opaque tag, and the oldest entry is always on lane 0. Dispatch logic uses the free-slot count and the ready flag to apply back-pressure.

Top module: `retire_slot_tracker`

## Requirements
- R1: After a synchronous active-high reset, the free-slot count equals DEPTH, no retire lane is valid, and the next dispatch token is 0.
- R2: A dispatch with a micro-op count of 0 occupies exactly one slot, so the free count drops by 1.
- R3: A micro-op count greater than DEPTH is clamped to DEPTH, so the free count drops by DEPTH.
- R4: The token of an accepted dispatch is the tail index before it. The tail then advances by the normalized count modulo DEPTH, so a reservation that crosses the end of the ring gives a next token that has wrapped to a small index.
- R5: `disp_ready` is 1 exactly when the free count is at least the normalized count. A dispatch presented while it is 0 changes neither the token nor the free count.
- R6: An entry whose completion has not been reported blocks retirement of every younger entry, including younger entries that have already completed.
- R7: Retiring an entry returns its normalized slot count to the free count and moves the head by that count modulo DEPTH. When idle, lane 0's token shows the head index.
- R8: No more than MAX_RETIRE entries retire in one cycle. With MAX_RETIRE = 0, every consecutive completed entry at the head retires in the same cycle.
- R9: A completion reported in a cycle can cause retirement no earlier than the following cycle.
- R10: Retire lanes are filled from lane 0 with no gaps, oldest entry first. Each valid lane carries the retired entry's token and its dispatch tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_uops | input | UOP_W | Micro-op count of the dispatched instruction |
| disp_tag | input | TAG_W | Opaque tag stored with the entry |
| disp_ready | output | 1 | Enough free slots for the current request |
| disp_token | output | IDX_W | Token that an accepted dispatch receives this cycle |
| done_valid | input | 1 | Completion report |
| done_token | input | IDX_W | Token of the completed entry |
| free_slots | output | CNT_W | Number of unclaimed slots |
| ret_valid | output | LANES | Per-lane retire strobe, lane 0 oldest |
| ret_token | output | LANES*IDX_W | Per-lane retired token (lane 0 shows the head when idle) |
| ret_tag | output | LANES*TAG_W | Per-lane retired tag |

## Verification
The hardest situation to reach from the ports is a head entry that is still pending while younger entries have already completed. Only then is the in-order stall visible, and only then can a burst of retirements hit the per-cycle cap. The stimulus dispatches three entries of different sizes and reports the two younger ones first. It holds the oldest back for several cycles and then releases it. It also watches the release cycle itself, to confirm that nothing retires before the next one. The same stimulus drives a second, unlimited instance, which must drain all three entries in a single cycle.

// File: rtl/retire_slot_tracker_pkg.sv
package retire_slot_tracker_pkg;

   // Ring addition for an index below depth plus a step of at most depth.
   function automatic int unsigned ring_add(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned depth);
      int unsigned sum;
      sum = base + step;
      return (sum >= depth) ? sum - depth : sum;
   endfunction

   // Zero micro-ops still need one slot; oversize requests saturate at depth.
   function automatic int unsigned fit_uops(input int unsigned uops,
                                            input int unsigned depth);
      if (uops == 0)     return 1;
      if (uops > depth)  return depth;
      return uops;
   endfunction

endpackage

// File: rtl/slot_normalizer.sv
module slot_normalizer
   import retire_slot_tracker_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int UOP_W = 6,
   parameter int CNT_W = 5
) (
   input  logic [UOP_W-1:0] uops,
   input  logic [CNT_W-1:0] free_cnt,
   output logic [CNT_W-1:0] norm_cnt,
   output logic             fits
);

   always_comb begin
      norm_cnt = CNT_W'(fit_uops(32'(uops), DEPTH));
      fits     = (free_cnt >= norm_cnt);
   end

endmodule

// File: rtl/slot_entry_table.sv
module slot_entry_table #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int TAG_W = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_idx,
   input  logic [CNT_W-1:0]            wr_cnt,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic                        set_en,
   input  logic [IDX_W-1:0]            set_idx,
   input  logic [DEPTH-1:0]            clr_mask,
   output logic [DEPTH-1:0][CNT_W-1:0] cnt_q,
   output logic [DEPTH-1:0][TAG_W-1:0] tag_q,
   output logic [DEPTH-1:0]            exec_q
);

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic hit_wr;
      logic hit_set;
      assign hit_wr  = wr_en  && (wr_idx  == IDX_W'(s));
      assign hit_set = set_en && (set_idx == IDX_W'(s));

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q[s]  <= '0;
            tag_q[s]  <= '0;
            exec_q[s] <= 1'b0;
         end else begin
            if (hit_wr) begin
               cnt_q[s] <= wr_cnt;
               tag_q[s] <= wr_tag;
            end
            // A fresh reservation always starts unexecuted; retirement
            // clears the flag so a stale completion never leaks forward.
            if (hit_wr)
               exec_q[s] <= 1'b0;
            else if (clr_mask[s])
               exec_q[s] <= 1'b0;
            else if (hit_set)
               exec_q[s] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/retire_chain.sv
module retire_chain
   import retire_slot_tracker_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int LANES = 2
) (
   input  logic [IDX_W-1:0]            head,
   input  logic [CNT_W-1:0]            used,
   input  logic [DEPTH-1:0][CNT_W-1:0] cnt_q,
   input  logic [DEPTH-1:0]            exec_q,
   output logic [LANES-1:0]            lane_vld,
   output logic [LANES-1:0][IDX_W-1:0] lane_idx,
   output logic [DEPTH-1:0]            clr_mask,
   output logic [CNT_W-1:0]            freed,
   output logic [IDX_W-1:0]            next_head
);

   logic [IDX_W-1:0] hp  [LANES+1];
   logic [CNT_W-1:0] rem [LANES+1];
   logic             go  [LANES+1];

   assign hp[0]  = head;
   assign rem[0] = used;
   assign go[0]  = 1'b1;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [CNT_W-1:0] span;
      assign span        = cnt_q[hp[l]];
      assign lane_vld[l] = go[l] && (rem[l] != '0) && exec_q[hp[l]];
      assign lane_idx[l] = hp[l];
      assign go[l+1]     = lane_vld[l];
      assign hp[l+1]     = lane_vld[l]
                           ? IDX_W'(ring_add(32'(hp[l]), 32'(span), DEPTH))
                           : hp[l];
      assign rem[l+1]    = lane_vld[l] ? rem[l] - span : rem[l];
   end

   assign freed     = used - rem[LANES];
   assign next_head = hp[LANES];

   always_comb begin
      clr_mask = '0;
      for (int l = 0; l < LANES; l++)
         if (lane_vld[l])
            clr_mask[lane_idx[l]] = 1'b1;
   end

endmodule

// File: rtl/retire_slot_tracker.sv
module retire_slot_tracker
   import retire_slot_tracker_pkg::*;
#(
   parameter  int DEPTH      = 16,
   parameter  int UOP_W      = 6,
   parameter  int TAG_W      = 8,
   parameter  int MAX_RETIRE = 2,
   localparam int IDX_W      = $clog2(DEPTH),
   localparam int CNT_W      = $clog2(DEPTH + 1),
   localparam int LANES      = (MAX_RETIRE == 0) ? DEPTH : MAX_RETIRE
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   disp_valid,
   input  logic [UOP_W-1:0]       disp_uops,
   input  logic [TAG_W-1:0]       disp_tag,
   output logic                   disp_ready,
   output logic [IDX_W-1:0]       disp_token,
   input  logic                   done_valid,
   input  logic [IDX_W-1:0]       done_token,
   output logic [CNT_W-1:0]       free_slots,
   output logic [LANES-1:0]       ret_valid,
   output logic [LANES*IDX_W-1:0] ret_token,
   output logic [LANES*TAG_W-1:0] ret_tag
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("retire_slot_tracker: DEPTH must be at least 2");
   end
   if (MAX_RETIRE < 0 || MAX_RETIRE > DEPTH) begin : g_bad_limit
      $error("retire_slot_tracker: MAX_RETIRE must lie in 0..DEPTH");
   end
   if (UOP_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("retire_slot_tracker: UOP_W and TAG_W must be positive");
   end

   logic [IDX_W-1:0]            head_q, tail_q, next_head;
   logic [CNT_W-1:0]            free_q, norm_cnt, freed, used;
   logic                        fits, fire;
   logic [DEPTH-1:0][CNT_W-1:0] cnt_q;
   logic [DEPTH-1:0][TAG_W-1:0] tag_q;
   logic [DEPTH-1:0]            exec_q, clr_mask;
   logic [LANES-1:0]            lane_vld;
   logic [LANES-1:0][IDX_W-1:0] lane_idx;

   slot_normalizer #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_norm (
      .uops     (disp_uops),
      .free_cnt (free_q),
      .norm_cnt (norm_cnt),
      .fits     (fits)
   );

   assign fire = disp_valid && fits;
   assign used = CNT_W'(DEPTH) - free_q;

   slot_entry_table #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .TAG_W(TAG_W)) u_table (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (fire),
      .wr_idx   (tail_q),
      .wr_cnt   (norm_cnt),
      .wr_tag   (disp_tag),
      .set_en   (done_valid),
      .set_idx  (done_token),
      .clr_mask (clr_mask),
      .cnt_q    (cnt_q),
      .tag_q    (tag_q),
      .exec_q   (exec_q)
   );

   retire_chain #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .LANES(LANES)) u_chain (
      .head      (head_q),
      .used      (used),
      .cnt_q     (cnt_q),
      .exec_q    (exec_q),
      .lane_vld  (lane_vld),
      .lane_idx  (lane_idx),
      .clr_mask  (clr_mask),
      .freed     (freed),
      .next_head (next_head)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         head_q <= '0;
         tail_q <= '0;
         free_q <= CNT_W'(DEPTH);
      end else begin
         head_q <= next_head;
         if (fire)
            tail_q <= IDX_W'(ring_add(32'(tail_q), 32'(norm_cnt), DEPTH));
         free_q <= free_q + freed - (fire ? norm_cnt : '0);
      end
   end

   assign disp_ready = fits;
   assign disp_token = tail_q;
   assign free_slots = free_q;
   assign ret_valid  = lane_vld;

   for (genvar l = 0; l < LANES; l++) begin : g_out
      assign ret_token[l*IDX_W +: IDX_W] = lane_idx[l];
      assign ret_tag[l*TAG_W +: TAG_W]   = tag_q[lane_idx[l]];
   end

endmodule

// File: rtl/retire_slot_tracker_chk.sv
module retire_slot_tracker_chk #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4,
   parameter int CNT_W = 5,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic [IDX_W-1:0] disp_token,
   input logic [CNT_W-1:0] free_slots,
   input logic [LANES-1:0] ret_valid
);

   logic [LANES:0] lane_inc;
   assign lane_inc = {1'b0, ret_valid} + (LANES+1)'(1);

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      free_slots <= CNT_W'(DEPTH));

   // R5
   stalled_token_chk: assert property (@(posedge clk) disable iff (rst)
      !(disp_valid && disp_ready) |=> $stable(disp_token));

   // R10
   lane_packed_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot(lane_inc));

   // R7
   retire_gain_chk: assert property (@(posedge clk) disable iff (rst)
      (ret_valid[0] && !(disp_valid && disp_ready)) |=> free_slots > $past(free_slots));

   // R7
   empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (free_slots == CNT_W'(DEPTH)) |-> !ret_valid[0]);

endmodule

bind retire_slot_tracker retire_slot_tracker_chk #(
   .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .LANES(LANES)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .disp_valid (disp_valid),
   .disp_ready (disp_ready),
   .disp_token (disp_token),
   .free_slots (free_slots),
   .ret_valid  (ret_valid)
);

// File: tb/retire_slot_tracker_tb.sv
module retire_slot_tracker_tb;

   localparam int DEPTH = 8;
   localparam int UOP_W = 4;
   localparam int TAG_W = 8;
   localparam int IW    = 3;
   localparam int CW    = 4;
   localparam int LN    = 2;
   localparam int LU    = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic disp_valid = 1'b0;
   logic [UOP_W-1:0] disp_uops = '0;
   logic [TAG_W-1:0] disp_tag = '0;
   logic done_valid = 1'b0;
   logic [IW-1:0] done_token = '0;

   logic disp_ready, u_ready;
   logic [IW-1:0] disp_token, u_token;
   logic [CW-1:0] free_slots, u_free;
   logic [LN-1:0] ret_valid;
   logic [LN*IW-1:0] ret_token;
   logic [LN*TAG_W-1:0] ret_tag;
   logic [LU-1:0] u_rvalid;
   logic [LU*IW-1:0] u_rtoken;
   logic [LU*TAG_W-1:0] u_rtag;

   always #2 clk = ~clk;

   retire_slot_tracker #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W), .MAX_RETIRE(2)) u_dut (
      .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_uops(disp_uops),
      .disp_tag(disp_tag), .disp_ready(disp_ready), .disp_token(disp_token),
      .done_valid(done_valid), .done_token(done_token), .free_slots(free_slots),
      .ret_valid(ret_valid), .ret_token(ret_token), .ret_tag(ret_tag));

   retire_slot_tracker #(.DEPTH(DEPTH), .UOP_W(UOP_W), .TAG_W(TAG_W), .MAX_RETIRE(0)) u_unl (
      .clk(clk), .rst(rst), .disp_valid(disp_valid), .disp_uops(disp_uops),
      .disp_tag(disp_tag), .disp_ready(u_ready), .disp_token(u_token),
      .done_valid(done_valid), .done_token(done_token), .free_slots(u_free),
      .ret_valid(u_rvalid), .ret_token(u_rtoken), .ret_tag(u_rtag));

   typedef struct packed {
      logic [IW-1:0]    tok;
      logic [TAG_W-1:0] tag;
   } exp_t;

   exp_t sbq[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   tail_m = 0;
   bit   done_f = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Scoreboard monitor: pops one expected entry per valid lane, oldest first.
   always @(negedge clk) begin
      if (!rst) begin
         for (int l = 0; l < LN; l++) begin
            if (ret_valid[l]) begin
               if (sbq.size() == 0) begin
                  chk(1'b0, "R10 unexpected retire", int'(ret_token[l*IW +: IW]), -1);
               end else begin
                  exp_t e;
                  e = sbq.pop_front();
                  chk(ret_token[l*IW +: IW] == e.tok, "R10 token",
                      int'(ret_token[l*IW +: IW]), int'(e.tok));
                  chk(ret_tag[l*TAG_W +: TAG_W] == e.tag, "R10 tag",
                      int'(ret_tag[l*TAG_W +: TAG_W]), int'(e.tag));
               end
            end
         end
      end
   end

   // Driver: starts and ends at a falling edge.
   task automatic dispatch(input int uops, input int tag);
      int n;
      n = (uops == 0) ? 1 : (uops > DEPTH ? DEPTH : uops);
      disp_valid = 1'b1;
      disp_uops  = UOP_W'(uops);
      disp_tag   = TAG_W'(tag);
      #1;
      chk(disp_ready == 1'b1, "R5 ready", int'(disp_ready), 1);
      chk(int'(disp_token) == tail_m, "R4 token", int'(disp_token), tail_m);
      sbq.push_back('{tok: IW'(tail_m), tag: TAG_W'(tag)});
      tail_m = (tail_m + n) % DEPTH;
      @(negedge clk);
      disp_valid = 1'b0;
   endtask

   task automatic complete(input int tok);
      done_valid = 1'b1;
      done_token = IW'(tok);
      #1;
      // R9: the completion being presented cannot retire anything now
      chk(ret_valid[0] == 1'b0 || ret_token[IW-1:0] != IW'(tok), "R9 same cycle",
          int'(ret_valid[0]), 0);
      @(negedge clk);
      done_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_f) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R1
      chk(free_slots == CW'(DEPTH), "R1 free", int'(free_slots), DEPTH);
      chk(ret_valid == '0, "R1 retire idle", int'(ret_valid), 0);
      chk(disp_token == '0, "R1 token", int'(disp_token), 0);
      @(negedge clk);

      // R2: zero micro-ops take one slot
      dispatch(0, 8'hA0);
      chk(free_slots == CW'(7), "R2 zero uop slot", int'(free_slots), 7);
      dispatch(3, 8'hB1);
      dispatch(2, 8'hC2);
      chk(free_slots == CW'(2), "R2 free after three", int'(free_slots), 2);

      // R6: younger entries complete first, head still pending
      complete(4);
      complete(1);
      @(negedge clk);
      chk(ret_valid == '0, "R6 head blocks", int'(ret_valid), 0);
      chk(u_rvalid == '0, "R6 head blocks unlimited", int'(u_rvalid), 0);
      chk(free_slots == CW'(2), "R6 free held", int'(free_slots), 2);

      complete(0);
      // R8: cap of two lanes, unlimited instance drains all three
      chk(ret_valid == 2'b11, "R8 capped burst", int'(ret_valid), 3);
      chk(u_rvalid == 8'b0000_0111, "R8 unlimited burst", int'(u_rvalid), 7);
      @(negedge clk);
      chk(ret_valid == 2'b01, "R8 remainder", int'(ret_valid), 1);
      chk(free_slots == CW'(6), "R7 free after two", int'(free_slots), 6);
      chk(u_free == CW'(8), "R8 unlimited free", int'(u_free), 8);
      @(negedge clk);
      chk(free_slots == CW'(8), "R7 all freed", int'(free_slots), 8);
      chk(ret_token[IW-1:0] == IW'(6), "R7 head index", int'(ret_token[IW-1:0]), 6);

      // R3: oversize request takes the whole ring
      dispatch(15, 8'hD3);
      chk(free_slots == CW'(0), "R3 clamp", int'(free_slots), 0);

      // R5: request refused while full is ignored
      disp_valid = 1'b1;
      disp_uops  = '0;
      disp_tag   = 8'h77;
      #1;
      chk(disp_ready == 1'b0, "R5 not ready", int'(disp_ready), 0);
      @(negedge clk);
      disp_valid = 1'b0;
      chk(disp_token == IW'(6), "R5 token kept", int'(disp_token), 6);
      chk(free_slots == CW'(0), "R5 free kept", int'(free_slots), 0);

      complete(6);
      chk(ret_valid == 2'b01, "R7 full entry retires", int'(ret_valid), 1);
      @(negedge clk);
      chk(free_slots == CW'(8), "R7 full entry freed", int'(free_slots), 8);
      chk(ret_token[IW-1:0] == IW'(6), "R7 head wrap", int'(ret_token[IW-1:0]), 6);

      // R4: reservation crossing the end of the ring
      dispatch(3, 8'hE4);
      chk(disp_token == IW'(1), "R4 wrapped tail", int'(disp_token), 1);
      dispatch(1, 8'hF5);
      complete(1);
      complete(6);
      chk(ret_valid == 2'b11, "R10 pair after wrap", int'(ret_valid), 3);
      repeat (3) @(negedge clk);
      chk(free_slots == CW'(8), "R7 drained", int'(free_slots), 8);
      chk(sbq.size() == 0, "R10 scoreboard empty", sbq.size(), 0);

      done_f = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule